// File: doc/BRIEF.md
# Serial Port Interrupt Identification Unit

This unit sits beside the receive and transmit paths of a 16550-style serial port. It collects five interrupt conditions: line errors, receive data at or above threshold, receive character timeout, transmit holding register empty and modem status change. It latches the conditions that arrive as events and applies a per-source enable to each one. A fixed priority then picks the single most urgent source. The unit registers the result as an 8-bit identification value for the host and drives one interrupt line from it.

Each latched source is cleared by the host access that services it. These accesses arrive as one-cycle strobes from the register decode outside the block. The identification read is different: it is a level that stays high for the whole host access. While it is high the reported value is frozen. New events are still latched during the freeze, and they show up once the access ends. A read that ends while transmit-empty is the reported source also clears that source.

Top module: `uart_intid`

## Requirements
- R1: After reset the identification value is 0x01 and the interrupt output is low.
- R2: The interrupt output is high exactly when bit 0 of the identification value is 0.
- R3: Bits 3..0 report the highest-priority enabled pending source. The order is line status (0110), then receive data (0100) or timeout (1100) sharing the second level, then transmit empty (0010), then modem status (0000). The code 0001 means nothing is pending.
- R4: A line error strobe latches the line status source. A line status register read strobe clears it, and a set in the same cycle wins.
- R5: Receive data is pending while the receive count is at or above the threshold. In FIFO mode the threshold is selected by trig_sel_i: 00→1, 01→4, 10→8, 11→14. Outside FIFO mode the threshold is 1.
- R6: A timeout strobe latches the timeout source only in FIFO mode. A receive buffer read strobe clears it, and so does leaving FIFO mode. Bit 3 is therefore never 1 outside FIFO mode.
- R7: The transmit-empty source is cleared by a transmit holding write strobe. It is also cleared when an identification read ends while 0010 is the reported code. A read that ends with another code reported leaves it pending.
- R8: A modem change strobe latches the modem source, and a modem status read strobe clears it.
- R9: Enable bits mask sources before priority: ien_i[0] covers receive data and timeout, [1] transmit empty, [2] line status, [3] modem. A masked source stays latched and is reported once it is enabled.
- R10: Bits 5..4 read 0. Bits 7..6 both equal the FIFO enable.
- R11: While rd_iir_i is high the identification value holds. Events recorded meanwhile appear on the first clock after it falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lsr_err_i | input | 1 | Overrun, parity, framing or break event strobe |
| rx_count_i | input | CNT_W | Bytes currently held in the receive path |
| rx_timeout_i | input | 1 | Receive character timeout event strobe |
| thr_empty_i | input | 1 | Transmit holding register became empty strobe |
| msr_change_i | input | 1 | Modem status change event strobe |
| ien_i | input | 4 | Per-source enables |
| fifo_en_i | input | 1 | FIFO mode enable |
| trig_sel_i | input | 2 | Receive threshold select |
| rd_iir_i | input | 1 | Identification register read in progress (level) |
| rd_lsr_i | input | 1 | Line status register read strobe |
| rd_rbr_i | input | 1 | Receive buffer read strobe |
| rd_msr_i | input | 1 | Modem status register read strobe |
| wr_thr_i | input | 1 | Transmit holding register write strobe |
| iid_o | output | 8 | Identification value |
| irq_o | output | 1 | Interrupt request |

## Verification
On every cycle, the assertions check four things: the hold of the identification value during a read, the link between the top bits and the FIFO enable, that a timeout code appears only in FIFO mode, and that an enabled line error always wins. They also check that an all-zero enable keeps the interrupt quiet. The bench scenarios are needed for the rest. They cover the full priority ladder with several sources pending at once and each clearing access peeling one level off. They also cover the threshold boundaries for each trigger setting, and the transmit-empty clear that depends on which code was being read when the access ended.

// File: rtl/uart_intid_pkg.sv
package uart_intid_pkg;

    typedef enum logic [3:0] {
        ID_NONE    = 4'b0001,
        ID_LINE    = 4'b0110,
        ID_RXDATA  = 4'b0100,
        ID_TIMEOUT = 4'b1100,
        ID_THRE    = 4'b0010,
        ID_MODEM   = 4'b0000
    } id_code_e;

    localparam int EN_RX    = 0;
    localparam int EN_TX    = 1;
    localparam int EN_LINE  = 2;
    localparam int EN_MODEM = 3;

    typedef struct packed {
        logic line;
        logic rxdata;
        logic timeout;
        logic thre;
        logic modem;
    } pend_t;

    function automatic int unsigned trig_bytes(input logic [1:0] sel);
        case (sel)
            2'b00:   return 1;
            2'b01:   return 4;
            2'b10:   return 8;
            default: return 14;
        endcase
    endfunction

endpackage

// File: rtl/uart_intid_srcs.sv
module uart_intid_srcs
    import uart_intid_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lsr_err_i,
    input  logic [CNT_W-1:0] rx_count_i,
    input  logic             rx_timeout_i,
    input  logic             thr_empty_i,
    input  logic             msr_change_i,
    input  logic             fifo_en_i,
    input  logic [1:0]       trig_sel_i,
    input  logic             rd_lsr_i,
    input  logic             rd_rbr_i,
    input  logic             rd_msr_i,
    input  logic             wr_thr_i,
    input  logic             iir_done_i,
    input  logic             thre_reported_i,
    output pend_t            pend_next_o
);

    typedef struct packed {
        logic line;
        logic timeout;
        logic thre;
        logic modem;
    } latch_t;

    latch_t st_d, st_q;
    logic [CNT_W-1:0] thresh;
    logic             rx_level;

    always_comb begin
        thresh   = fifo_en_i ? CNT_W'(trig_bytes(trig_sel_i)) : CNT_W'(1);
        rx_level = (rx_count_i >= thresh);

        st_d = st_q;
        // events win over clears in the same cycle
        if (rd_lsr_i)                      st_d.line = 1'b0;
        if (lsr_err_i)                     st_d.line = 1'b1;

        if (rd_rbr_i || !fifo_en_i)        st_d.timeout = 1'b0;
        if (rx_timeout_i && fifo_en_i)     st_d.timeout = 1'b1;

        if (wr_thr_i || (iir_done_i && thre_reported_i)) st_d.thre = 1'b0;
        if (thr_empty_i)                   st_d.thre = 1'b1;

        if (rd_msr_i)                      st_d.modem = 1'b0;
        if (msr_change_i)                  st_d.modem = 1'b1;

        pend_next_o.line    = st_d.line;
        pend_next_o.rxdata  = rx_level;
        pend_next_o.timeout = st_d.timeout;
        pend_next_o.thre    = st_d.thre;
        pend_next_o.modem   = st_d.modem;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/uart_intid_prio.sv
module uart_intid_prio
    import uart_intid_pkg::*;
(
    input  pend_t      pend_i,
    input  logic [3:0] ien_i,
    output id_code_e   code_o
);

    always_comb begin
        if (pend_i.line && ien_i[EN_LINE])          code_o = ID_LINE;
        else if (pend_i.rxdata && ien_i[EN_RX])     code_o = ID_RXDATA;
        else if (pend_i.timeout && ien_i[EN_RX])    code_o = ID_TIMEOUT;
        else if (pend_i.thre && ien_i[EN_TX])       code_o = ID_THRE;
        else if (pend_i.modem && ien_i[EN_MODEM])   code_o = ID_MODEM;
        else                                        code_o = ID_NONE;
    end

endmodule

// File: rtl/uart_intid.sv
module uart_intid
    import uart_intid_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lsr_err_i,
    input  logic [CNT_W-1:0] rx_count_i,
    input  logic             rx_timeout_i,
    input  logic             thr_empty_i,
    input  logic             msr_change_i,
    input  logic [3:0]       ien_i,
    input  logic             fifo_en_i,
    input  logic [1:0]       trig_sel_i,
    input  logic             rd_iir_i,
    input  logic             rd_lsr_i,
    input  logic             rd_rbr_i,
    input  logic             rd_msr_i,
    input  logic             wr_thr_i,
    output logic [7:0]       iid_o,
    output logic             irq_o
);

    typedef struct packed {
        logic [7:0] iid;
        logic       rd_hold;
    } top_t;

    top_t     st_d, st_q;
    pend_t    pend_next;
    id_code_e code;
    logic     iir_done;
    logic     thre_reported;

    assign iir_done      = st_q.rd_hold && !rd_iir_i;
    assign thre_reported = (st_q.iid[3:0] == ID_THRE);

    uart_intid_srcs #(.CNT_W(CNT_W)) u_srcs (
        .clk             (clk),
        .rst_n           (rst_n),
        .lsr_err_i       (lsr_err_i),
        .rx_count_i      (rx_count_i),
        .rx_timeout_i    (rx_timeout_i),
        .thr_empty_i     (thr_empty_i),
        .msr_change_i    (msr_change_i),
        .fifo_en_i       (fifo_en_i),
        .trig_sel_i      (trig_sel_i),
        .rd_lsr_i        (rd_lsr_i),
        .rd_rbr_i        (rd_rbr_i),
        .rd_msr_i        (rd_msr_i),
        .wr_thr_i        (wr_thr_i),
        .iir_done_i      (iir_done),
        .thre_reported_i (thre_reported),
        .pend_next_o     (pend_next)
    );

    uart_intid_prio u_prio (
        .pend_i (pend_next),
        .ien_i  (ien_i),
        .code_o (code)
    );

    always_comb begin
        st_d         = st_q;
        st_d.rd_hold = rd_iir_i;
        if (!rd_iir_i) begin
            st_d.iid = {{2{fifo_en_i}}, 2'b00, code};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{iid: 8'h01, rd_hold: 1'b0};
        else        st_q <= st_d;
    end

    assign iid_o = st_q.iid;
    assign irq_o = !st_q.iid[0];

endmodule

// File: rtl/uart_intid_chk.sv
module uart_intid_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_iir_i,
    input logic       fifo_en_i,
    input logic       lsr_err_i,
    input logic [3:0] ien_i,
    input logic [7:0] iid_o,
    input logic       irq_o
);

    logic seen;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen <= 1'b0;
        else        seen <= 1'b1;
    end

    // R11: value held across a read cycle
    a_r11_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        seen && rd_iir_i |=> $stable(iid_o));

    // R10: top bits follow the FIFO enable of the previous cycle
    a_r10_fifo_bits: assert property (@(posedge clk) disable iff (!rst_n)
        seen && !$past(rd_iir_i) |-> iid_o[7:6] == {2{$past(fifo_en_i)}});

    // R6: timeout code only with FIFO flags set
    a_r6_timeout_fifo_only: assert property (@(posedge clk) disable iff (!rst_n)
        iid_o[3] |-> iid_o[7:6] == 2'b11);

    // R4: an enabled line error is reported at once
    a_r4_line_first: assert property (@(posedge clk) disable iff (!rst_n)
        seen && !$past(rd_iir_i) && $past(lsr_err_i) && $past(ien_i[2])
        |-> iid_o[3:0] == 4'b0110);

    // R9: nothing enabled, nothing reported
    a_r9_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        seen && !$past(rd_iir_i) && $past(ien_i) == 4'b0000
        |-> !irq_o && iid_o[3:0] == 4'b0001);

endmodule

bind uart_intid uart_intid_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_iir_i  (rd_iir_i),
    .fifo_en_i (fifo_en_i),
    .lsr_err_i (lsr_err_i),
    .ien_i     (ien_i),
    .iid_o     (iid_o),
    .irq_o     (irq_o)
);

// File: tb/tb_uart_intid.sv
module tb_uart_intid;

    localparam int PERIOD = 10;
    localparam int CNT_W  = 5;
    localparam int NV     = 11;
    // {fifo_en, trig_sel, rx_count, ien, expected iid}
    localparam logic [19:0] VEC [NV] = '{
        {1'b0, 2'd0, 5'd0,  4'hF, 8'h01},
        {1'b0, 2'd0, 5'd1,  4'h1, 8'h04},
        {1'b1, 2'd1, 5'd3,  4'h1, 8'hC1},
        {1'b1, 2'd1, 5'd4,  4'h1, 8'hC4},
        {1'b1, 2'd2, 5'd7,  4'h1, 8'hC1},
        {1'b1, 2'd2, 5'd8,  4'h1, 8'hC4},
        {1'b1, 2'd3, 5'd13, 4'h1, 8'hC1},
        {1'b1, 2'd3, 5'd14, 4'h1, 8'hC4},
        {1'b1, 2'd0, 5'd1,  4'h1, 8'hC4},
        {1'b0, 2'd0, 5'd5,  4'h0, 8'h01},
        {1'b1, 2'd0, 5'd0,  4'hF, 8'hC1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lsr_err = 0, rx_timeout = 0, thr_empty = 0, msr_change = 0;
    logic [CNT_W-1:0] rx_cnt = '0;
    logic [3:0] ien = 4'hF;
    logic fifo_en = 0;
    logic [1:0] trig_sel = 0;
    logic rd_iir = 0, rd_lsr = 0, rd_rbr = 0, rd_msr = 0, wr_thr = 0;
    logic [7:0] iid;
    logic irq;
    logic [7:0] exp_v;
    int n_chk = 0;
    int n_fail = 0;

    always #(PERIOD/2) clk = ~clk;

    uart_intid dut (
        .clk(clk), .rst_n(rst_n), .lsr_err_i(lsr_err), .rx_count_i(rx_cnt),
        .rx_timeout_i(rx_timeout), .thr_empty_i(thr_empty), .msr_change_i(msr_change),
        .ien_i(ien), .fifo_en_i(fifo_en), .trig_sel_i(trig_sel), .rd_iir_i(rd_iir),
        .rd_lsr_i(rd_lsr), .rd_rbr_i(rd_rbr), .rd_msr_i(rd_msr), .wr_thr_i(wr_thr),
        .iid_o(iid), .irq_o(irq)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input logic [7:0] exp, input string tag);
        n_chk++;
        if (iid !== exp) begin
            n_fail++;
            $display("FAIL %s: iid_o=%02h expected %02h", tag, iid, exp);
        end
        n_chk++;
        if (irq !== !exp[0]) begin
            n_fail++;
            $display("FAIL R2 (%s): irq_o=%0b expected %0b", tag, irq, !exp[0]);
        end
    endtask

    initial begin
        #(PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        chk(8'h01, "R1 in reset");
        step();
        rst_n = 1'b1;
        step();
        chk(8'h01, "R1 after reset");

        // R5 threshold table and R10 flag bits
        for (int i = 0; i < NV; i++) begin
            {fifo_en, trig_sel, rx_cnt, ien, exp_v} = VEC[i];
            step();
            chk(exp_v, "R5 vector");
        end

        // R3 all sources at once, then peel levels off
        fifo_en = 0; ien = 4'hF; rx_cnt = 1;
        lsr_err = 1; thr_empty = 1; msr_change = 1;
        step();
        lsr_err = 0; thr_empty = 0; msr_change = 0;
        chk(8'h06, "R3 line highest");
        rd_lsr = 1; step(); rd_lsr = 0;
        chk(8'h04, "R4 cleared, R3 rx data next");
        rx_cnt = 0; step();
        chk(8'h02, "R5 count drop, R3 thre next");
        wr_thr = 1; step(); wr_thr = 0;
        chk(8'h00, "R7 thr write, R3 modem last");
        rd_msr = 1; step(); rd_msr = 0;
        chk(8'h01, "R8 modem cleared");

        // R6 timeout in FIFO mode beats THRE
        fifo_en = 1; trig_sel = 2'd3; rx_cnt = 2; ien = 4'h3;
        thr_empty = 1; step(); thr_empty = 0;
        chk(8'hC2, "R6 thre pending");
        rx_timeout = 1; step(); rx_timeout = 0;
        chk(8'hCC, "R6 timeout code");
        rd_rbr = 1; step(); rd_rbr = 0;
        chk(8'hC2, "R6 timeout cleared by rbr read");
        wr_thr = 1; step(); wr_thr = 0;
        chk(8'hC1, "R7 thr write");

        // R6 timeout ignored outside FIFO mode
        fifo_en = 0; rx_cnt = 0; ien = 4'hF;
        rx_timeout = 1; step(); rx_timeout = 0;
        chk(8'h01, "R6 no timeout without FIFO");

        // R11 freeze, R7 clear on read of THRE
        thr_empty = 1; step(); thr_empty = 0;
        chk(8'h02, "R7 thre set");
        rd_iir = 1; step();
        chk(8'h02, "R11 during read");
        msr_change = 1; step(); msr_change = 0;
        chk(8'h02, "R11 frozen with new event");
        step();
        chk(8'h02, "R11 still frozen");
        rd_iir = 0; step();
        chk(8'h00, "R11 release, R7 thre cleared by read");
        rd_msr = 1; step(); rd_msr = 0;
        chk(8'h01, "R8 modem cleared");

        // R7 read while another code reported keeps THRE
        lsr_err = 1; thr_empty = 1; step(); lsr_err = 0; thr_empty = 0;
        chk(8'h06, "R4 line set");
        rd_iir = 1; step(); rd_iir = 0; step();
        chk(8'h06, "R7 read of line code");
        rd_lsr = 1; step(); rd_lsr = 0;
        chk(8'h02, "R7 thre survives other read");
        wr_thr = 1; step(); wr_thr = 0;
        chk(8'h01, "R7 thr write");

        // R9 masking keeps latched state
        ien = 4'h0;
        lsr_err = 1; step(); lsr_err = 0;
        chk(8'h01, "R9 masked line error");
        ien = 4'h4; step();
        chk(8'h06, "R9 unmasked line error");
        rd_lsr = 1; lsr_err = 1; step(); rd_lsr = 0; lsr_err = 0;
        chk(8'h06, "R4 set wins over clear");
        rd_lsr = 1; step(); rd_lsr = 0;
        chk(8'h01, "R4 cleared");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule